// File: doc/BRIEF.md
# Slow-Infrared Receive Unwrapping Filter

This block sits between a slow-infrared byte receiver and a receive FIFO. It watches a stream of recovered bytes, finds frames delimited by a start flag (0xC0) and a stop flag (0xC1), and strips the framing. Repeated leading start flags are dropped, escape sequences are undone, and only payload bytes reach the output. The two trailing frame check bytes are payload from the filter's point of view, so they are passed through untouched. Bytes seen between frames are thrown away.

Each forwarded byte comes out one clock after it was accepted. A start marker flags the first byte of a frame, and a one-cycle stop marker closes it. Three error flags are valid together with the stop marker: start flag inside an open frame, escape followed by a flag, and frame longer than the programmed limit. A 12-bit counter shows how many bytes of the current frame have been forwarded. The two fixed flag values can be read as one 16-bit constant word.

The control core is a four-state machine:
- `ST_IDLE`: outside any frame. A start flag opens a frame and moves to `ST_LEAD`.
- `ST_LEAD`: inside the run of leading start flags. A further start flag stays here. An ordinary byte is forwarded and moves to `ST_BODY`. A stop flag closes an empty frame and returns to `ST_IDLE`. An escape moves to `ST_ESC`.
- `ST_BODY`: payload. An ordinary byte is forwarded. An escape moves to `ST_ESC`. A stop flag closes the frame and returns to `ST_IDLE`. A start flag closes the frame with the misplaced-start error, opens a new frame and moves to `ST_LEAD`.
- `ST_ESC`: one byte after an escape. Any non-flag byte (a second escape included) is forwarded XOR 0x20 and the state moves to `ST_BODY`. A stop flag closes the frame with the encoding error and returns to `ST_IDLE`. A start flag closes the frame with the encoding error, opens a new frame and moves to `ST_LEAD`.

Top module: `sir_unwrap_filter`

## Requirements
- R1: `flag_word` always reads 16'hC1C0: the start flag 0xC0 sits in bits [7:0] and the stop flag 0xC1 in bits [15:8].
- R2: Bytes that arrive outside a frame never produce `out_valid`. This covers bytes before the first start flag, bytes after a stop flag, and bytes after a frame closed with an encoding error.
- R3: Start and stop flag bytes never appear on the output.
  - Leading repeated start flags are dropped.
  - Each payload byte, the two trailing check bytes included, appears on `out_byte` with `out_valid` high one cycle after it is accepted.
  - `out_sof` is high with the first forwarded byte of a frame.
- R4: An escape byte 0x7D is dropped. The byte after it is forwarded XOR 0x20 (for example 0x7D 0xE0 gives 0xC0, and 0x7D 0x5D gives 0x7D).
- R5: A stop flag in an open frame gives a one-cycle `out_eof` with `out_valid` low and all error flags low, unless another error applies.
- R6: A start flag after payload in an open frame gives `out_eof` with `err_sirbad` high. It also opens a new frame, whose next data byte carries `out_sof`.
- R7: An escape followed directly by a start or stop flag gives `out_eof` with `err_phy` high. A start flag opens a new frame; a stop flag returns to idle.
- R8: `byte_count` clears when a frame opens. It then rises by one in the same cycle that each forwarded byte appears on the output.
- R9: Once a frame has forwarded `max_len` bytes, further payload bytes are discarded and not counted. The frame's `out_eof` then carries `err_length` high; a frame of exactly `max_len` bytes does not.
- R10: After reset, `out_valid`, `out_sof`, `out_eof`, all error flags and `byte_count` are 0.
- R11: A cycle with `in_valid` low produces no output and leaves the frame state and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_byte | input | 8 | Received byte |
| max_len | input | 12 | Largest number of bytes forwarded per frame |
| out_valid | output | 1 | Forwarded byte present |
| out_byte | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | Frame closed (no data this cycle) |
| err_sirbad | output | 1 | Start flag inside open frame, valid with out_eof |
| err_phy | output | 1 | Escape followed by a flag, valid with out_eof |
| err_length | output | 1 | Frame exceeded max_len, valid with out_eof |
| byte_count | output | 12 | Bytes forwarded in the current frame |
| flag_word | output | 16 | Fixed flags: stop in [15:8], start in [7:0] |

## Verification
The filter is exercised with these input patterns:
- A clean frame that has leading extra start flags and stray bytes on both sides. This separates flag removal from idle discarding.
- Escaped payloads whose results equal the flag and escape values themselves. This shows that decoding happens after classification.
- A start flag arriving mid-frame, and escapes cut short by either flag. These tell the misplaced-start error apart from the encoding error, and show whether a new frame is reopened.
- Length tests with frames of exactly the limit and one byte over it, plus gaps in `in_valid` inside a frame. These pin down the counter's boundary and its hold behaviour.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;
    localparam logic [7:0] FLAG_BOF = 8'hC0;
    localparam logic [7:0] FLAG_EOF = 8'hC1;
    localparam logic [7:0] ESC_CHAR = 8'h7D;
    localparam logic [7:0] ESC_XOR  = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BODY,
        ST_ESC
    } rx_state_t;

    typedef enum logic [1:0] {
        CL_DATA,
        CL_BOF,
        CL_EOF,
        CL_ESC
    } byte_class_t;
endpackage

// File: rtl/sir_byte_classify.sv
module sir_byte_classify
    import sir_unwrap_pkg::*;
(
    input  logic [7:0]  byte_i,
    output byte_class_t cls_o
);
    always_comb begin
        if (byte_i == FLAG_BOF)      cls_o = CL_BOF;
        else if (byte_i == FLAG_EOF) cls_o = CL_EOF;
        else if (byte_i == ESC_CHAR) cls_o = CL_ESC;
        else                         cls_o = CL_DATA;
    end
endmodule

// File: rtl/sir_frame_fsm.sv
module sir_frame_fsm
    import sir_unwrap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  byte_class_t cls,
    output logic        act_pass,
    output logic [7:0]  act_byte,
    output logic        act_open,
    output logic        act_close,
    output logic        act_sirbad,
    output logic        act_phy
);
    rx_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        act_pass   = 1'b0;
        act_byte   = in_byte;
        act_open   = 1'b0;
        act_close  = 1'b0;
        act_sirbad = 1'b0;
        act_phy    = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cls == CL_BOF) begin
                        act_open = 1'b1;
                        state_d  = ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    unique case (cls)
                        CL_BOF:  state_d = ST_LEAD;
                        CL_EOF: begin
                            act_close = 1'b1;
                            state_d   = ST_IDLE;
                        end
                        CL_ESC:  state_d = ST_ESC;
                        default: begin
                            act_pass = 1'b1;
                            state_d  = ST_BODY;
                        end
                    endcase
                end
                ST_BODY: begin
                    unique case (cls)
                        CL_BOF: begin
                            act_close  = 1'b1;
                            act_sirbad = 1'b1;
                            act_open   = 1'b1;
                            state_d    = ST_LEAD;
                        end
                        CL_EOF: begin
                            act_close = 1'b1;
                            state_d   = ST_IDLE;
                        end
                        CL_ESC:  state_d = ST_ESC;
                        default: act_pass = 1'b1;
                    endcase
                end
                ST_ESC: begin
                    unique case (cls)
                        CL_BOF: begin
                            act_close = 1'b1;
                            act_phy   = 1'b1;
                            act_open  = 1'b1;
                            state_d   = ST_LEAD;
                        end
                        CL_EOF: begin
                            act_close = 1'b1;
                            act_phy   = 1'b1;
                            state_d   = ST_IDLE;
                        end
                        default: begin
                            act_pass = 1'b1;
                            act_byte = in_byte ^ ESC_XOR;
                            state_d  = ST_BODY;
                        end
                    endcase
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    AST_IDLE_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !act_pass); // R2
    AST_CLOSE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        act_close |-> (in_valid && (cls == CL_BOF || cls == CL_EOF))); // R5
    AST_HOLD_WHEN_IDLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (state_q == $past(state_q))); // R11
endmodule

// File: rtl/sir_frame_counter.sv
module sir_frame_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             pass_i,
    input  logic [CNT_W-1:0] max_len,
    output logic [CNT_W-1:0] cnt_o,
    output logic             room_o,
    output logic             first_o,
    output logic             over_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign room_o = (cnt_o < max_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            first_o <= 1'b0;
            over_o  <= 1'b0;
        end else if (open_i) begin
            cnt_o   <= '0;
            first_o <= 1'b1;
            over_o  <= 1'b0;
        end else if (pass_i) begin
            if (room_o) begin
                cnt_o   <= cnt_o + ONE;
                first_o <= 1'b0;
            end else begin
                over_o  <= 1'b1;
            end
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == '0 || cnt_o == $past(cnt_o) + ONE)); // R8
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_i && !open_i && !room_o) |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/sir_unwrap_filter.sv
module sir_unwrap_filter
    import sir_unwrap_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [CNT_W-1:0] max_len,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sof,
    output logic             out_eof,
    output logic             err_sirbad,
    output logic             err_phy,
    output logic             err_length,
    output logic [CNT_W-1:0] byte_count,
    output logic [15:0]      flag_word
);
    byte_class_t cls;
    logic        act_pass, act_open, act_close, act_sirbad, act_phy;
    logic [7:0]  act_byte;
    logic        room, first, over;

    assign flag_word = {FLAG_EOF, FLAG_BOF};

    sir_byte_classify u_cls (
        .byte_i (in_byte),
        .cls_o  (cls)
    );

    sir_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .cls        (cls),
        .act_pass   (act_pass),
        .act_byte   (act_byte),
        .act_open   (act_open),
        .act_close  (act_close),
        .act_sirbad (act_sirbad),
        .act_phy    (act_phy)
    );

    sir_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (act_open),
        .pass_i  (act_pass),
        .max_len (max_len),
        .cnt_o   (byte_count),
        .room_o  (room),
        .first_o (first),
        .over_o  (over)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_byte   <= '0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            err_sirbad <= 1'b0;
            err_phy    <= 1'b0;
            err_length <= 1'b0;
        end else begin
            out_valid  <= act_pass && room;
            out_sof    <= act_pass && room && first;
            if (act_pass && room) out_byte <= act_byte;
            out_eof    <= act_close;
            err_sirbad <= act_close && act_sirbad;
            err_phy    <= act_close && act_phy;
            err_length <= act_close && over;
        end
    end

    AST_FLAG_NOT_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_byte == FLAG_BOF || in_byte == FLAG_EOF)) |=> !out_valid); // R3
    AST_QUIET_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_eof)); // R11
    AST_SOF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid); // R3
    AST_ERR_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sirbad || err_phy || err_length) |-> (out_eof && !out_valid)); // R5
    AST_FLAG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word == 16'hC1C0); // R1
endmodule

// File: tb/tb_sir_unwrap_filter.sv
`timescale 1ns/1ps
module tb_sir_unwrap_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [11:0] max_len = 12'd100;
    logic        out_valid, out_sof, out_eof, err_sirbad, err_phy, err_length;
    logic [7:0]  out_byte;
    logic [11:0] byte_count;
    logic [15:0] flag_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sir_unwrap_filter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .max_len(max_len), .out_valid(out_valid), .out_byte(out_byte),
        .out_sof(out_sof), .out_eof(out_eof), .err_sirbad(err_sirbad),
        .err_phy(err_phy), .err_length(err_length), .byte_count(byte_count),
        .flag_word(flag_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic v, input logic [7:0] b,
                              input logic sof, input logic eof, input logic [11:0] cnt);
        chk({tag, " valid"}, out_valid, v);
        if (v) chk({tag, " byte"}, out_byte, b);
        chk({tag, " sof"}, out_sof, sof);
        chk({tag, " eof"}, out_eof, eof);
        chk({tag, " count"}, byte_count, cnt);
    endtask

    task automatic expect_err(input string tag, input logic sb, input logic ph, input logic ln);
        chk({tag, " sirbad"}, err_sirbad, sb);
        chk({tag, " phy"}, err_phy, ph);
        chk({tag, " length"}, err_length, ln);
    endtask

    task automatic t_reset();
        expect_out("R10 reset", 1'b0, 8'h00, 1'b0, 1'b0, 12'd0);
        expect_err("R10 reset", 1'b0, 1'b0, 1'b0);
        chk("R1 flag word", flag_word, 32'h0000C1C0);
    endtask

    task automatic t_basic();
        send(8'h11); expect_out("R2 pre-frame", 1'b0, 8'h00, 1'b0, 1'b0, 12'd0);
        send(8'hC0); expect_out("R3 bof", 1'b0, 8'h00, 1'b0, 1'b0, 12'd0);
        send(8'hC0); expect_out("R3 xbof", 1'b0, 8'h00, 1'b0, 1'b0, 12'd0);
        send(8'hC0); expect_out("R3 xbof2", 1'b0, 8'h00, 1'b0, 1'b0, 12'd0);
        send(8'hA1); expect_out("R3 first", 1'b1, 8'hA1, 1'b1, 1'b0, 12'd1);
        send(8'hA2); expect_out("R8 second", 1'b1, 8'hA2, 1'b0, 1'b0, 12'd2);
        gap();       expect_out("R11 gap", 1'b0, 8'h00, 1'b0, 1'b0, 12'd2);
        send(8'h33); expect_out("R3 fcs lo", 1'b1, 8'h33, 1'b0, 1'b0, 12'd3);
        send(8'h44); expect_out("R3 fcs hi", 1'b1, 8'h44, 1'b0, 1'b0, 12'd4);
        send(8'hC1); expect_out("R5 eof", 1'b0, 8'h00, 1'b0, 1'b1, 12'd4);
        expect_err("R5 eof clean", 1'b0, 1'b0, 1'b0);
        send(8'h55); expect_out("R2 post-frame", 1'b0, 8'h00, 1'b0, 1'b0, 12'd4);
    endtask

    task automatic t_escape();
        send(8'hC0);
        send(8'h7D); expect_out("R4 esc dropped", 1'b0, 8'h00, 1'b0, 1'b0, 12'd0);
        send(8'h5D); expect_out("R4 esc 7D", 1'b1, 8'h7D, 1'b1, 1'b0, 12'd1);
        send(8'h7D);
        send(8'hE0); expect_out("R4 esc C0", 1'b1, 8'hC0, 1'b0, 1'b0, 12'd2);
        send(8'h7D);
        send(8'hE1); expect_out("R4 esc C1", 1'b1, 8'hC1, 1'b0, 1'b0, 12'd3);
        send(8'hC1); expect_out("R4 eof", 1'b0, 8'h00, 1'b0, 1'b1, 12'd3);
        expect_err("R4 eof clean", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_sirbad();
        send(8'hC0);
        send(8'h01);
        send(8'h02); expect_out("R6 data", 1'b1, 8'h02, 1'b0, 1'b0, 12'd2);
        send(8'hC0); expect_out("R6 bof in frame", 1'b0, 8'h00, 1'b0, 1'b1, 12'd0);
        expect_err("R6 bof in frame", 1'b1, 1'b0, 1'b0);
        send(8'h03); expect_out("R6 reopened", 1'b1, 8'h03, 1'b1, 1'b0, 12'd1);
        send(8'hC1); expect_out("R6 eof", 1'b0, 8'h00, 1'b0, 1'b1, 12'd1);
        expect_err("R6 eof clean", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_phy();
        send(8'hC0);
        send(8'h09);
        send(8'h7D);
        send(8'hC1); expect_out("R7 esc eof", 1'b0, 8'h00, 1'b0, 1'b1, 12'd1);
        expect_err("R7 esc eof", 1'b0, 1'b1, 1'b0);
        send(8'h0A); expect_out("R2 after abort", 1'b0, 8'h00, 1'b0, 1'b0, 12'd1);
        send(8'hC0);
        send(8'h7D);
        send(8'hC0); expect_out("R7 esc bof", 1'b0, 8'h00, 1'b0, 1'b1, 12'd0);
        expect_err("R7 esc bof", 1'b0, 1'b1, 1'b0);
        send(8'h0B); expect_out("R7 reopened", 1'b1, 8'h0B, 1'b1, 1'b0, 12'd1);
        send(8'hC1); expect_err("R7 eof clean", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_length();
        max_len = 12'd3;
        send(8'hC0);
        send(8'h21); send(8'h22);
        send(8'h23); expect_out("R9 at limit", 1'b1, 8'h23, 1'b0, 1'b0, 12'd3);
        send(8'h24); expect_out("R9 over dropped", 1'b0, 8'h00, 1'b0, 1'b0, 12'd3);
        send(8'hC1); expect_out("R9 eof", 1'b0, 8'h00, 1'b0, 1'b1, 12'd3);
        expect_err("R9 over", 1'b0, 1'b0, 1'b1);
        send(8'hC0);
        send(8'h31); send(8'h32); send(8'h33);
        send(8'hC1); expect_err("R9 exact", 1'b0, 1'b0, 1'b0);
        max_len = 12'd100;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_escape();
        t_sirbad();
        t_phy();
        t_length();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule